// File: doc/BRIEF.md
# Serial Wire Sequence Shifter

This block moves raw bit sequences over a two-wire debug link made of a clock output and a bidirectional data line. A host starts a sequence with a one-cycle pulse. It supplies a bit count, a mode select, a direction flag and a half-period divider setting with that pulse. Outgoing bits are pulled one byte at a time through a valid/ready byte port and sent least significant bit first. Captured bits come back through a second valid/ready byte port.

Pattern mode clocks out any number of bits up to the full 32-bit count. It is meant for line resets and mode-switch patterns. Short mode handles up to 64 bits, and the direction flag decides whether it drives or captures. In capture, the data line is released and each bit is sampled at the end of its low clock phase. When the last byte is only partly filled, it is right-aligned. The link waits with its clock held high whenever a byte has not yet been supplied or taken, so the host sets the pace without breaking the link timing.

Top module: `swd_seq_shifter`

## Requirements
- R1: Each bit is one low phase of `swclk_o` followed by one high phase. A low phase lasts exactly `div_i`+1 system clocks, with `div_i` latched at start. A high phase lasts at least `div_i`+1 system clocks. While idle, `swclk_o` is high.
- R2: With `short_mode_i`=0, exactly `count_i` bits are clocked. The data line is driven whatever `capture_i` says. Bit i is bit (i mod 8) of the (i/8)-th byte taken on the tx port, and one byte is taken for every started group of 8 bits. A count of 0 gives no clock edge and still ends with a done pulse.
- R3: With `short_mode_i`=1, only `count_i[5:0]` sets the length and the other count bits are ignored. A field value of 0 means 64 bits.
- R4: While busy, `swdio_o` changes only in system cycles where `swclk_o` is low.
- R5: In a short-mode capture, `swdio_oe_o` is 0 from the cycle after start until the done pulse. In every drive sequence it is 1 at each rising edge of `swclk_o`.
- R6: In capture, the bit present on `swdio_i` at the end of the low phase of bit i goes to position (i mod 8) of the (i/8)-th byte delivered on the rx port. One byte is delivered per group of 8 bits.
- R7: If the capture length is not a multiple of 8, the last rx byte carries its k bits in positions 0..k-1, and its upper bits are 0.
- R8: `busy_o` rises the cycle after an accepted start with a non-zero length. It stays high until the last high phase ends. `done_o` then pulses for exactly one cycle, during which `busy_o` is 0.
- R9: While a tx byte is awaited (`tx_ready_o`=1) or an rx byte waits to be taken (`rx_valid_o`=1), `swclk_o` stays high and the bit stream stays intact.
- R10: A start pulse while busy is ignored, and the running sequence keeps its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle start request |
| short_mode_i | input | 1 | 0: pattern mode, 1: short mode |
| capture_i | input | 1 | Short mode: 1 capture, 0 drive |
| count_i | input | 32 | Bit count (short mode uses bits 5:0, 0 means 64) |
| div_i | input | 16 | Half-period in system clocks minus one; 0 is fastest |
| tx_data_i | input | 8 | Outgoing byte, LSB sent first |
| tx_valid_i | input | 1 | Outgoing byte valid |
| tx_ready_o | output | 1 | Block accepts an outgoing byte |
| rx_data_o | output | 8 | Captured byte, right-aligned |
| rx_valid_o | output | 1 | Captured byte valid |
| rx_ready_i | input | 1 | Host takes the captured byte |
| swclk_o | output | 1 | Serial clock |
| swdio_o | output | 1 | Serial data out |
| swdio_oe_o | output | 1 | Serial data output enable |
| swdio_i | input | 1 | Serial data in |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case is a capture that ends part-way through a byte while the host is slow on both byte ports. This case combines right alignment, stalls with the clock held high, and the last-bit branch. Random runs draw short-mode lengths from 1 to 64, including non-multiples of 8. They also draw random divider values and random valid/ready gaps on both byte ports. Directed runs cover a zero length, a 64-bit run selected by a zero field with upper count bits set, and a start pulse issued mid-sequence. A bench-side wire model answers every falling clock edge with a fresh random bit. It also records the bit seen at every rising edge, so the packed bytes can be predicted from the pattern alone.

// File: rtl/swseq_pkg.sv
package swseq_pkg;
  localparam int BYTE_W = 8;
  typedef enum logic [2:0] {
    S_IDLE, S_PREP, S_FETCH, S_LOW, S_HIGH, S_PUSH, S_DONE
  } swseq_st_e;
endpackage

// File: rtl/swseq_tick.sv
module swseq_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             expired_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= div_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/swseq_rxpack.sv
module swseq_rxpack #(
  parameter int W  = 8,
  localparam int PW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          shift_i,
  input  logic          bit_i,
  input  logic [PW-1:0] fill_i,   // bits in current byte, 0 = full
  output logic [W-1:0]  data_o
);
  logic [W-1:0]  sr_q;
  logic [PW-1:0] sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (shift_i) sr_q <= {bit_i, sr_q[W-1:1]};
  end

  // W is a power of two: W - fill wraps to 0 for a full byte
  assign sh     = PW'(0) - fill_i;
  assign data_o = sr_q >> sh;
endmodule

// File: rtl/swd_seq_shifter.sv
module swd_seq_shifter
  import swseq_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int DIV_W   = 16,
  parameter int SHORT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             short_mode_i,
  input  logic             capture_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [7:0]       tx_data_i,
  input  logic             tx_valid_i,
  output logic             tx_ready_o,
  output logic [7:0]       rx_data_o,
  output logic             rx_valid_o,
  input  logic             rx_ready_i,
  output logic             swclk_o,
  output logic             swdio_o,
  output logic             swdio_oe_o,
  input  logic             swdio_i,
  output logic             busy_o,
  output logic             done_o
);
  localparam int PW        = $clog2(BYTE_W);
  localparam int SHORT_MAX = 1 << SHORT_W;

  swseq_st_e        st_q;
  logic [CNT_W-1:0] remain_q, nbits;
  logic [PW-1:0]    pos_q;
  logic [7:0]       tx_sr_q;
  logic [DIV_W-1:0] div_q;
  logic             cap_q, clk_q, dio_q, oe_q;
  logic             expired, load, need_byte, last_bit, rx_shift;

  always_comb begin
    if (short_mode_i)
      nbits = (count_i[SHORT_W-1:0] == '0) ? CNT_W'(SHORT_MAX)
                                           : CNT_W'(count_i[SHORT_W-1:0]);
    else
      nbits = count_i;
  end

  assign need_byte = !cap_q && (pos_q == '0);
  assign last_bit  = (remain_q == CNT_W'(1));
  assign load      = (st_q == S_PREP && !need_byte) ||
                     (st_q == S_FETCH && tx_valid_i) ||
                     (st_q == S_LOW && expired);
  assign rx_shift  = (st_q == S_LOW) && expired && cap_q;

  swseq_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .div_i     (div_q),
    .expired_o (expired)
  );

  swseq_rxpack #(.W(BYTE_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (rx_shift),
    .bit_i   (swdio_i),
    .fill_i  (pos_q),
    .data_o  (rx_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      remain_q <= '0;
      pos_q    <= '0;
      tx_sr_q  <= '0;
      div_q    <= '0;
      cap_q    <= 1'b0;
      clk_q    <= 1'b1;
      dio_q    <= 1'b1;
      oe_q     <= 1'b1;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_i) begin
          remain_q <= nbits;
          pos_q    <= '0;
          div_q    <= div_i;
          cap_q    <= short_mode_i && capture_i;
          oe_q     <= !(short_mode_i && capture_i);
          st_q     <= (nbits == '0) ? S_DONE : S_PREP;
        end
        S_PREP: begin
          if (need_byte) st_q <= S_FETCH;
          else begin
            clk_q <= 1'b0;
            if (!cap_q) dio_q <= tx_sr_q[0];
            st_q  <= S_LOW;
          end
        end
        S_FETCH: if (tx_valid_i) begin
          tx_sr_q <= tx_data_i;
          clk_q   <= 1'b0;
          dio_q   <= tx_data_i[0];
          st_q    <= S_LOW;
        end
        S_LOW: if (expired) begin
          clk_q <= 1'b1;
          st_q  <= S_HIGH;
        end
        S_HIGH: if (expired) begin
          remain_q <= remain_q - 1'b1;
          pos_q    <= pos_q + 1'b1;
          tx_sr_q  <= tx_sr_q >> 1;
          if (cap_q && (pos_q == PW'(BYTE_W-1) || last_bit)) st_q <= S_PUSH;
          else if (last_bit)                                 st_q <= S_DONE;
          else                                               st_q <= S_PREP;
        end
        S_PUSH: if (rx_ready_i)
          st_q <= (remain_q == '0) ? S_DONE : S_PREP;
        S_DONE: begin
          oe_q <= 1'b1;
          st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign tx_ready_o = (st_q == S_FETCH);
  assign rx_valid_o = (st_q == S_PUSH);
  assign busy_o     = (st_q != S_IDLE) && (st_q != S_DONE);
  assign done_o     = (st_q == S_DONE);
  assign swclk_o    = clk_q;
  assign swdio_o    = dio_q;
  assign swdio_oe_o = oe_q;
endmodule

// File: rtl/swseq_checker.sv
module swseq_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic tx_ready_o,
  input logic rx_valid_o,
  input logic swclk_o,
  input logic swdio_o,
  input logic swdio_oe_o,
  input logic busy_o,
  input logic done_o
);
  a_r1_idle_clk_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> swclk_o);

  a_r4_data_chg_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !$stable(swdio_o)) |-> !swclk_o);

  a_r5_capture_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> !swdio_oe_o);

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r8_start_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !done_o) |=> (busy_o || done_o));

  a_r9_stall_clk_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ready_o || rx_valid_o) |-> swclk_o);

  a_r9_one_side_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_ready_o && rx_valid_o));
endmodule

bind swd_seq_shifter swseq_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .tx_ready_o (tx_ready_o),
  .rx_valid_o (rx_valid_o),
  .swclk_o    (swclk_o),
  .swdio_o    (swdio_o),
  .swdio_oe_o (swdio_oe_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/sim_swd_seq_shifter.sv
module sim_swd_seq_shifter;
  logic        clk_i = 0, rst_ni = 0;
  logic        start_i = 0, short_mode_i = 0, capture_i = 0;
  logic [31:0] count_i = '0;
  logic [15:0] div_i = '0;
  logic [7:0]  tx_data_i;
  logic        tx_valid_i = 1, rx_ready_i = 1;
  logic        tx_ready_o, rx_valid_o, swclk_o, swdio_o, swdio_oe_o, busy_o, done_o;
  logic [7:0]  rx_data_o;
  logic        swdio_i = 0;

  always #5 clk_i = ~clk_i;

  swd_seq_shifter u0 (.*);

  int n_run = 0, n_fail = 0, cyc = 0;
  logic [7:0] tx_mem [16];
  logic [7:0] rx_got [16];
  bit   cap_pat [128];
  bit   drv_bits [128];
  int   tx_idx, rx_cnt, rise_cnt, fall_cnt, oe_bad, chg_bad, stall_bad;
  int   low_run, low_min, low_max;
  bit   exp_oe, stall_en;
  logic prev_dio;

  assign tx_data_i = tx_mem[tx_idx[3:0]];

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", msg, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (tx_ready_o && tx_valid_i) tx_idx <= tx_idx + 1;
    if (rx_valid_o && rx_ready_i) begin
      rx_got[rx_cnt[3:0]] <= rx_data_o;
      rx_cnt <= rx_cnt + 1;
    end
  end

  always @(posedge swclk_o) if (rst_ni && busy_o) begin
    if (rise_cnt < 128) drv_bits[rise_cnt] = swdio_o;
    if (swdio_oe_o != exp_oe) oe_bad++;
    rise_cnt++;
  end

  always @(negedge swclk_o) if (rst_ni) begin
    automatic int k = fall_cnt;
    fall_cnt++;
    #1 swdio_i = cap_pat[k % 128];
  end

  always @(negedge clk_i) begin
    tx_valid_i <= stall_en ? ($urandom % 3 != 0) : 1'b1;
    rx_ready_i <= stall_en ? ($urandom % 3 != 0) : 1'b1;
    if (rst_ni && busy_o) begin
      if (swdio_o !== prev_dio && swclk_o) chg_bad++;
      if ((tx_ready_o || rx_valid_o) && !swclk_o) stall_bad++;
      if (!swclk_o) low_run++;
      else if (low_run > 0) begin
        if (low_run < low_min) low_min = low_run;
        if (low_run > low_max) low_max = low_run;
        low_run = 0;
      end
      if (!exp_oe && swdio_oe_o) oe_bad++;
    end
    prev_dio = swdio_o;
  end

  function automatic logic [7:0] exp_rx(input int j, input int n);
    logic [7:0] v = '0;
    for (int b = 0; b < 8; b++)
      if (8*j + b < n) v[b] = cap_pat[8*j + b];
    return v;
  endfunction

  task automatic run(input bit sm, input bit cp, input logic [31:0] cnt,
                     input logic [15:0] dv, input bit stl, input bit restart);
    int n, w, nb, bad;
    bit capx;
    n    = sm ? ((cnt[5:0] == 0) ? 64 : int'(cnt[5:0])) : int'(cnt);
    capx = sm && cp;
    nb   = (n + 7) / 8;
    for (int i = 0; i < 16; i++) tx_mem[i] = 8'($urandom);
    for (int i = 0; i < 128; i++) cap_pat[i] = 1'($urandom);
    @(negedge clk_i);
    tx_idx = 0; rx_cnt = 0; rise_cnt = 0; fall_cnt = 0;
    oe_bad = 0; chg_bad = 0; stall_bad = 0;
    low_run = 0; low_min = 1 << 30; low_max = 0;
    exp_oe = !capx; stall_en = stl;
    start_i = 1; short_mode_i = sm; capture_i = cp; count_i = cnt; div_i = dv;
    @(negedge clk_i);
    start_i = 0; div_i = 16'hFFFF; count_i = 32'h3;
    if (n > 0) chk(busy_o == 1, "R8 busy after start", busy_o, 1);
    if (restart && n > 4) begin
      repeat (7) @(negedge clk_i);
      start_i = 1; short_mode_i = 1; capture_i = 0;
      @(negedge clk_i);
      start_i = 0;
    end
    w = 0;
    while (!done_o && w < 30000) begin @(negedge clk_i); w++; end
    chk(w < 30000, "R8 done reached (watchdog)", w, 30000);
    chk(busy_o == 0, "R8 busy low during done", busy_o, 0);
    @(negedge clk_i);
    chk(done_o == 0, "R8 done one cycle", done_o, 0);
    chk(swclk_o == 1, "R1 idle clock high", swclk_o, 1);
    chk(rise_cnt == n, sm ? "R3 short length" : (restart ? "R10 length kept" : "R2 pattern length"),
        rise_cnt, n);
    if (n > 0) begin
      chk(low_min == dv + 1 && low_max == dv + 1, "R1 low phase length", low_max, dv + 1);
      chk(oe_bad == 0, "R5 output enable", oe_bad, 0);
      chk(stall_bad == 0, "R9 clock held in stall", stall_bad, 0);
    end
    if (!capx) begin
      bad = 0;
      for (int i = 0; i < n && i < 128; i++)
        if (drv_bits[i] != tx_mem[i/8][i%8]) bad++;
      chk(bad == 0, stl ? "R9 drive bits with stalls" : "R2 drive bits LSB first", bad, 0);
      chk(tx_idx == nb, "R2 bytes fetched", tx_idx, nb);
      chk(chg_bad == 0, "R4 data change only while low", chg_bad, 0);
    end else begin
      chk(rx_cnt == nb, "R6 bytes delivered", rx_cnt, nb);
      for (int j = 0; j < nb && j < 16; j++)
        chk(rx_got[j] == exp_rx(j, n), (8*j + 8 > n && n % 8 != 0) ?
            "R7 partial byte aligned" : "R6 capture byte", rx_got[j], exp_rx(j, n));
    end
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk_i);
    chk(busy_o == 0 && done_o == 0 && swclk_o == 1, "R8 reset state", busy_o, 0);
    rst_ni = 1;
    @(negedge clk_i);
    run(0, 0, 32'd100, 16'd0, 0, 0);           // R2 long pattern, fastest
    run(0, 1, 32'd13, 16'd2, 0, 0);            // R2 direction ignored in pattern mode
    run(0, 0, 32'd0, 16'd1, 0, 0);             // R2 zero count
    run(1, 0, 32'hFFFF_FF40, 16'd0, 0, 0);     // R3 zero field -> 64, upper bits ignored
    run(1, 1, 32'd0, 16'd1, 1, 0);             // R3/R6 64-bit capture with stalls
    run(1, 1, 32'd13, 16'd3, 1, 0);            // R7 partial byte
    run(1, 1, 32'd1, 16'd0, 0, 0);             // R7 single bit
    run(1, 0, 32'd20, 16'd1, 0, 1);            // R10 restart ignored
    for (int r = 0; r < 20; r++)
      run(1, 1'($urandom), 32'($urandom), 16'($urandom % 5), 1'($urandom), 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 190000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired act=%0d exp=0", cyc);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule